// File: doc/BRIEF.md
# CAN Bit Timing and Synchronization Unit

This block derives the bit clock of a CAN node from the peripheral clock. A prescaler divides the clock into time quanta. Each bit is built from quanta in three phases: a one-quantum sync phase, a first phase of programmable length, and a second phase of programmable length. The line is sampled where the first phase ends. The unit outputs a quantum tick, a sample strobe that carries the sampled level, and a bit-start strobe that the transmitter uses to launch its next bit.

The unit tracks the bus in two ways. A falling edge (recessive to dominant) seen while the bus is idle restarts the bit (hard synchronization). A falling edge seen during a frame moves the bit boundary (resynchronization): an edge in the first phase lengthens that phase, and an edge in the second phase shortens that phase. The correction is limited to a programmable number of quanta, and only one correction is made per bit. The unit also routes the transmit and receive paths for the internal loop-back and listen-only test modes.

Configuration fields are held in registers. They are captured from the configuration inputs on a load strobe and take their documented defaults on reset. Every length is stored as its value minus one.

Top module: `can_bit_timer`

## Requirements
- R1: `tq_tick` is a one-cycle pulse repeating every (divider + 1) clock cycles. With divider 0 it is high on every cycle.
- R2: With no edges, a bit lasts (3 + seg1 + seg2) quanta. `bit_start` pulses once per bit, and `sample_stb` pulses (seg1 + 2) quanta after each `bit_start`.
- R3: After reset and before any load, the fields are divider 0, seg1 3, seg2 2, resync width 1, both test modes off. During reset `tx_pin` is 1 and every strobe is 0.
- R4: A valid falling edge in the first phase lengthens that phase by min(e, resync width + 1) quanta. Here e is 1 plus the count of first-phase quanta that have already ended when the edge is seen. An edge seen during the sync phase changes nothing.
- R5: A valid falling edge in the second phase shortens that phase by min(r, resync width + 1) quanta. Here r is the count of second-phase quanta still left after the quantum in which the edge is seen.
- R6: At most one edge per bit is used for resynchronization. Later edges in the same bit are ignored.
- R7: While `bus_idle` is 1, a valid falling edge restarts the bit at its sync phase and pulses `bit_start` in the tick where the edge is seen.
- R8: Levels: 1 is recessive and 0 is dominant. An edge seen while the node itself drives dominant (`tx_bit` = 0, not in listen-only mode) is ignored. Rising edges are always ignored.
- R9: In loop-back mode, `tx_pin` is 1, the internal receive path takes `tx_bit`, and `rx_pin` has no effect.
- R10: In listen-only mode, `tx_pin` is 1, the receive path takes `rx_pin`, and `tx_bit` is treated as recessive for R8.
- R11: `sample_bit` is the internal receive level at the sample tick. Outside the test modes, `tx_pin` follows `tx_bit` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_pin | input | 1 | Bus receive line |
| tx_bit | input | 1 | Bit from the transmitter |
| bus_idle | input | 1 | High while no frame is in progress |
| cfg_load | input | 1 | Captures all configuration inputs |
| cfg_div | input | DIV_W | Quantum divider minus one |
| cfg_seg1 | input | SEG1_W | First phase length minus one |
| cfg_seg2 | input | SEG2_W | Second phase length minus one |
| cfg_sjw | input | SJW_W | Resync limit minus one |
| cfg_loop | input | 1 | Internal loop-back enable |
| cfg_listen | input | 1 | Listen-only enable |
| tx_pin | output | 1 | Bus transmit line |
| tq_tick | output | 1 | Time-quantum pulse |
| sample_stb | output | 1 | Sample-point strobe |
| sample_bit | output | 1 | Level sampled at the strobe |
| bit_start | output | 1 | Start of a new bit |

## Verification
The bench builds the block with its default widths: a 12-bit divider, a 4-bit first phase, a 3-bit second phase and a 2-bit resync limit. It then varies the runtime fields instead. Divider 0 makes every cycle a quantum, so the bench can place each edge in a chosen quantum and predict the bit length to the cycle. Divider 2 exercises the tick spacing and the scaled bit and sample positions. Resync limits of 0, 1 and 3 move the cap above and below the phase error. Both phases at their minimum length (one quantum each) and at their maximum length bound the bit length, which then spans from 3 to 25 quanta.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  typedef enum logic [1:0] {
    PH_SYNC = 2'd0,
    PH_ONE  = 2'd1,
    PH_TWO  = 2'd2
  } phase_e;
endpackage

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/can_bt_route.sv
module can_bt_route (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic rx_pin,
  input  logic tx_bit,
  input  logic loop_en,
  input  logic listen_en,
  output logic rx_int,
  output logic fall,
  output logic tx_pin
);
  logic rx_prev;
  logic own_dom;

  // internal receive path: transmitter output in loop-back, bus otherwise
  assign rx_int  = loop_en ? tx_bit : rx_pin;
  // in listen-only the node never drives dominant
  assign own_dom = ~listen_en & ~tx_bit;
  assign fall    = tick & rx_prev & ~rx_int & ~own_dom;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_prev <= 1'b1;
      tx_pin  <= 1'b1;
    end else begin
      if (tick) rx_prev <= rx_int;
      tx_pin <= (loop_en | listen_en) ? 1'b1 : tx_bit;
    end
  end
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
  import can_bt_pkg::*;
#(
  parameter int SEG1_W = 4,
  parameter int SEG2_W = 3,
  parameter int SJW_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              fall,
  input  logic              bus_idle,
  input  logic              rx_int,
  input  logic [SEG1_W-1:0] seg1,
  input  logic [SEG2_W-1:0] seg2,
  input  logic [SJW_W-1:0]  sjw,
  output logic              sample_stb,
  output logic              sample_bit,
  output logic              bit_start
);
  localparam int WMAX = (SEG1_W > SEG2_W) ? SEG1_W : SEG2_W;
  localparam int CW   = ((WMAX > SJW_W) ? WMAX : SJW_W) + 2;

  phase_e        phase;
  logic [CW-1:0] qcnt, ext, shr;
  logic          rs_done;

  logic [CW-1:0] len1, len2, cap, err1, rem2, ext_n, shr_n;
  logic          resync, hard, end1, end2;

  function automatic logic [CW-1:0] min_q(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return (a < b) ? a : b;
  endfunction

  always_comb begin
    len1   = CW'(seg1) + CW'(1);
    len2   = CW'(seg2) + CW'(1);
    cap    = CW'(sjw) + CW'(1);
    hard   = fall & bus_idle;
    resync = fall & ~bus_idle & ~rs_done;
    err1   = qcnt + CW'(1);
    rem2   = len2 - CW'(1) - qcnt;
    ext_n  = (resync && phase == PH_ONE) ? min_q(err1, cap) : ext;
    shr_n  = (resync && phase == PH_TWO) ? min_q(rem2, cap) : shr;
    end1   = (qcnt == len1 - CW'(1) + ext_n);
    end2   = (qcnt >= len2 - CW'(1) - shr_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_SYNC;
      qcnt       <= '0;
      ext        <= '0;
      shr        <= '0;
      rs_done    <= 1'b0;
      sample_stb <= 1'b0;
      sample_bit <= 1'b1;
      bit_start  <= 1'b0;
    end else begin
      sample_stb <= 1'b0;
      bit_start  <= 1'b0;
      if (tick) begin
        if (hard) begin
          phase     <= PH_SYNC;
          qcnt      <= '0;
          ext       <= '0;
          shr       <= '0;
          rs_done   <= 1'b1;
          bit_start <= 1'b1;
        end else begin
          case (phase)
            PH_SYNC: begin
              phase   <= PH_ONE;
              qcnt    <= '0;
              ext     <= '0;
              shr     <= '0;
              rs_done <= rs_done | resync;
            end
            PH_ONE: begin
              ext <= ext_n;
              if (resync) rs_done <= 1'b1;
              if (end1) begin
                phase      <= PH_TWO;
                qcnt       <= '0;
                sample_stb <= 1'b1;
                sample_bit <= rx_int;
              end else begin
                qcnt <= qcnt + CW'(1);
              end
            end
            PH_TWO: begin
              if (end2) begin
                phase     <= PH_SYNC;
                qcnt      <= '0;
                shr       <= '0;
                rs_done   <= 1'b0;
                bit_start <= 1'b1;
              end else begin
                shr  <= shr_n;
                qcnt <= qcnt + CW'(1);
                if (resync) rs_done <= 1'b1;
              end
            end
            default: phase <= PH_SYNC;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int DIV_W  = 12,
  parameter int SEG1_W = 4,
  parameter int SEG2_W = 3,
  parameter int SJW_W  = 2,
  parameter logic [DIV_W-1:0]  DIV_INIT  = '0,
  parameter logic [SEG1_W-1:0] SEG1_INIT = SEG1_W'(3),
  parameter logic [SEG2_W-1:0] SEG2_INIT = SEG2_W'(2),
  parameter logic [SJW_W-1:0]  SJW_INIT  = SJW_W'(1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_pin,
  input  logic              tx_bit,
  input  logic              bus_idle,
  input  logic              cfg_load,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [SEG1_W-1:0] cfg_seg1,
  input  logic [SEG2_W-1:0] cfg_seg2,
  input  logic [SJW_W-1:0]  cfg_sjw,
  input  logic              cfg_loop,
  input  logic              cfg_listen,
  output logic              tx_pin,
  output logic              tq_tick,
  output logic              sample_stb,
  output logic              sample_bit,
  output logic              bit_start
);
  logic [DIV_W-1:0]  div_q;
  logic [SEG1_W-1:0] seg1_q;
  logic [SEG2_W-1:0] seg2_q;
  logic [SJW_W-1:0]  sjw_q;
  logic              loop_q, listen_q;
  logic              rx_int, fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q    <= DIV_INIT;
      seg1_q   <= SEG1_INIT;
      seg2_q   <= SEG2_INIT;
      sjw_q    <= SJW_INIT;
      loop_q   <= 1'b0;
      listen_q <= 1'b0;
    end else if (cfg_load) begin
      div_q    <= cfg_div;
      seg1_q   <= cfg_seg1;
      seg2_q   <= cfg_seg2;
      sjw_q    <= cfg_sjw;
      loop_q   <= cfg_loop;
      listen_q <= cfg_listen;
    end
  end

  can_bt_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk  (clk),
    .rst  (rst),
    .div  (div_q),
    .tick (tq_tick)
  );

  can_bt_route u_route (
    .clk       (clk),
    .rst       (rst),
    .tick      (tq_tick),
    .rx_pin    (rx_pin),
    .tx_bit    (tx_bit),
    .loop_en   (loop_q),
    .listen_en (listen_q),
    .rx_int    (rx_int),
    .fall      (fall),
    .tx_pin    (tx_pin)
  );

  can_bt_seq #(.SEG1_W(SEG1_W), .SEG2_W(SEG2_W), .SJW_W(SJW_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .tick       (tq_tick),
    .fall       (fall),
    .bus_idle   (bus_idle),
    .rx_int     (rx_int),
    .seg1       (seg1_q),
    .seg2       (seg2_q),
    .sjw        (sjw_q),
    .sample_stb (sample_stb),
    .sample_bit (sample_bit),
    .bit_start  (bit_start)
  );
endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk #(
  parameter int DIV_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             tq_tick,
  input logic             sample_stb,
  input logic             sample_bit,
  input logic             bit_start,
  input logic             tx_pin,
  input logic             tx_bit,
  input logic             loop_q,
  input logic             listen_q,
  input logic [DIV_W-1:0] div_q
);
  // R1: with a divider above zero the tick never lasts two cycles
  p_tick_single_r1: assert property (@(posedge clk) disable iff (rst)
    (tq_tick && div_q != '0) |=> !tq_tick);

  // R2: a sample strobe is a single-cycle pulse
  p_sample_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    sample_stb |=> !sample_stb);

  // R2: sample point and bit start never coincide
  p_no_overlap_r2: assert property (@(posedge clk) disable iff (rst)
    !(sample_stb && bit_start));

  // R9: loop-back keeps the bus recessive
  p_loop_tx_r9: assert property (@(posedge clk) disable iff (rst)
    loop_q |=> tx_pin);

  // R10: listen-only keeps the bus recessive
  p_listen_tx_r10: assert property (@(posedge clk) disable iff (rst)
    listen_q |=> tx_pin);

  // R9: in loop-back the sampled level is the transmitted level
  p_loop_sample_r9: assert property (@(posedge clk) disable iff (rst)
    (sample_stb && $past(loop_q)) |-> (sample_bit == $past(tx_bit)));
endmodule

bind can_bit_timer can_bit_timer_chk #(.DIV_W(DIV_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tq_tick    (tq_tick),
  .sample_stb (sample_stb),
  .sample_bit (sample_bit),
  .bit_start  (bit_start),
  .tx_pin     (tx_pin),
  .tx_bit     (tx_bit),
  .loop_q     (loop_q),
  .listen_q   (listen_q),
  .div_q      (div_q)
);

// File: tb/test_can_bit_timer.sv
`timescale 1ns/1ps
module test_can_bit_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_pin = 1'b1, tx_bit = 1'b1, bus_idle = 1'b0, cfg_load = 1'b0;
  logic [11:0] cfg_div = '0;
  logic [3:0]  cfg_seg1 = 4'd3;
  logic [2:0]  cfg_seg2 = 3'd2;
  logic [1:0]  cfg_sjw = 2'd1;
  logic        cfg_loop = 1'b0, cfg_listen = 1'b0;
  logic        tx_pin, tq_tick, sample_stb, sample_bit, bit_start;

  int checks = 0;
  int errors = 0;
  int    exp_len[$];
  string exp_tag[$];
  int    since = 0;
  bit    armed = 1'b0;

  always #5 clk = ~clk;

  can_bit_timer i_can_bit_timer (
    .clk(clk), .rst(rst), .rx_pin(rx_pin), .tx_bit(tx_bit), .bus_idle(bus_idle),
    .cfg_load(cfg_load), .cfg_div(cfg_div), .cfg_seg1(cfg_seg1), .cfg_seg2(cfg_seg2),
    .cfg_sjw(cfg_sjw), .cfg_loop(cfg_loop), .cfg_listen(cfg_listen),
    .tx_pin(tx_pin), .tq_tick(tq_tick), .sample_stb(sample_stb),
    .sample_bit(sample_bit), .bit_start(bit_start)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: measures bit lengths between bit_start pulses
  always @(negedge clk) begin
    if (!rst) begin
      since++;
      if (bit_start) begin
        if (armed && exp_len.size() > 0) begin
          chk(since == exp_len[0], exp_tag[0], since, exp_len[0]);
          void'(exp_len.pop_front());
          void'(exp_tag.pop_front());
        end
        armed = (exp_len.size() > 0);
        since = 0;
      end
    end
  end

  task automatic wait_bs();
    do @(negedge clk); while (!bit_start);
  endtask

  task automatic drain();
    while (exp_len.size() != 0) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic expect_bit(input int len, input string tag);
    exp_len.push_back(len);
    exp_tag.push_back(tag);
    wait_bs();
    @(posedge clk);
  endtask

  // falling edge on rx_pin d cycles after the bit_start observation
  task automatic drive_bit(input int d, input int len, input string tag);
    exp_len.push_back(len);
    exp_tag.push_back(tag);
    wait_bs();
    repeat (d) @(negedge clk);
    rx_pin = 1'b0;
    @(negedge clk);
    rx_pin = 1'b1;
    @(posedge clk);
  endtask

  task automatic load_cfg(input int dv, input int s1, input int s2, input int sj,
                          input bit lp, input bit ls);
    drain();
    @(negedge clk);
    cfg_div = 12'(dv); cfg_seg1 = 4'(s1); cfg_seg2 = 3'(s2); cfg_sjw = 2'(sj);
    cfg_loop = lp; cfg_listen = ls; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    wait_bs();
    wait_bs();
    @(posedge clk);
  endtask

  task automatic chk_sample_pos(input int exp, input string tag);
    int n = 0;
    drain();
    wait_bs();
    do begin @(negedge clk); n++; end while (!sample_stb);
    chk(n == exp, tag, n, exp);
  endtask

  task automatic chk_tick_gap(input int exp, input string tag);
    int n = 0;
    drain();
    do @(negedge clk); while (!tq_tick);
    do begin @(negedge clk); n++; end while (!tq_tick);
    chk(n == exp, tag, n, exp);
  endtask

  task automatic chk_sample_val(input bit txv, input bit rxv, input bit exp, input string tag);
    drain();
    wait_bs();
    tx_bit = txv; rx_pin = rxv;
    do @(negedge clk); while (!sample_stb);
    chk(sample_bit == exp, tag, sample_bit, exp);
    tx_bit = 1'b1; rx_pin = 1'b1;
    @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R3 reset state
    chk(tx_pin == 1'b1, "R3 tx_pin in reset", tx_pin, 1);
    chk(sample_stb == 1'b0, "R3 sample_stb in reset", sample_stb, 0);
    chk(bit_start == 1'b0, "R3 bit_start in reset", bit_start, 0);
    chk(tq_tick == 1'b0, "R3 tq_tick in reset", tq_tick, 0);
    rst = 1'b0;
    wait_bs();
    wait_bs();
    @(posedge clk);

    // R1 divider 0: tick every cycle; R2 sample position by default fields
    chk_tick_gap(1, "R1 tick gap div0");
    chk_sample_pos(5, "R2 sample offset default");
    drive_bit(0, 8, "R3 default bit length");
    drive_bit(0, 8, "R4 edge in sync phase");
    // R11 tx_pin follows tx_bit with modes off (also R3 modes off)
    drain();
    @(negedge clk); tx_bit = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(tx_pin == 1'b0, "R11 tx_pin follows dominant", tx_pin, 0);
    tx_bit = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(tx_pin == 1'b1, "R11 tx_pin follows recessive", tx_pin, 1);
    @(posedge clk);

    // R4 lengthening, cap = 2 by default
    drive_bit(1, 9, "R4 lengthen by 1");
    drive_bit(3, 10, "R4 capped lengthen");
    drive_bit(4, 10, "R4 capped lengthen late");
    // R5 shortening
    drive_bit(5, 6, "R5 shorten by 2");
    drive_bit(6, 7, "R5 shorten by 1");
    drive_bit(7, 8, "R5 edge in last quantum");

    // R6 one correction per bit
    exp_len.push_back(9); exp_tag.push_back("R6 second edge ignored");
    wait_bs();
    @(negedge clk); rx_pin = 1'b0;
    @(negedge clk); rx_pin = 1'b1;
    @(negedge clk); rx_pin = 1'b0;
    @(negedge clk); rx_pin = 1'b1;
    @(posedge clk);

    // R8 own dominant edge ignored
    drain();
    tx_bit = 1'b0;
    drive_bit(2, 8, "R8 own dominant edge");
    drain();
    tx_bit = 1'b1;
    @(posedge clk);

    // R11 sample value normal mode
    chk_sample_val(1'b1, 1'b0, 1'b0, "R11 sampled dominant");
    chk_sample_val(1'b1, 1'b1, 1'b1, "R11 sampled recessive");

    // R7 hard synchronization
    drain();
    bus_idle = 1'b1;
    drive_bit(2, 3, "R7 hard sync restart");
    expect_bit(8, "R7 bit after hard sync");
    drain();
    bus_idle = 1'b0;
    @(posedge clk);

    // resync width 0 and 3
    load_cfg(0, 3, 2, 0, 1'b0, 1'b0);
    drive_bit(2, 9, "R4 cap 1");
    drive_bit(5, 7, "R5 cap 1");
    load_cfg(0, 3, 2, 3, 1'b0, 1'b0);
    drive_bit(4, 12, "R4 cap 4");

    // phase length extremes
    load_cfg(0, 0, 0, 1, 1'b0, 1'b0);
    expect_bit(3, "R2 minimum bit");
    load_cfg(0, 15, 7, 1, 1'b0, 1'b0);
    expect_bit(25, "R2 maximum bit");

    // R9 loop-back
    load_cfg(0, 3, 2, 1, 1'b1, 1'b0);
    @(negedge clk); tx_bit = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(tx_pin == 1'b1, "R9 tx_pin recessive in loop-back", tx_pin, 1);
    tx_bit = 1'b1;
    @(posedge clk);
    drive_bit(2, 8, "R9 rx_pin ignored in loop-back");
    exp_len.push_back(8); exp_tag.push_back("R9 looped own edge ignored");
    wait_bs();
    repeat (2) @(negedge clk);
    tx_bit = 1'b0;
    @(negedge clk); tx_bit = 1'b1;
    @(posedge clk);
    chk_sample_val(1'b0, 1'b1, 1'b0, "R9 sample follows tx_bit");

    // R10 listen-only
    load_cfg(0, 3, 2, 1, 1'b0, 1'b1);
    @(negedge clk); tx_bit = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(tx_pin == 1'b1, "R10 tx_pin recessive in listen-only", tx_pin, 1);
    drive_bit(2, 10, "R10 edge used while tx_bit low");
    drain();
    tx_bit = 1'b1;
    @(posedge clk);
    chk_sample_val(1'b0, 1'b1, 1'b1, "R10 sample follows rx_pin");

    // R1 divider 2
    load_cfg(2, 3, 2, 1, 1'b0, 1'b0);
    chk_tick_gap(3, "R1 tick gap div2");
    chk_sample_pos(15, "R2 sample offset div2");
    expect_bit(24, "R1 bit length div2");
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule